// File: doc/BRIEF.md
# Double-Buffered Gamma Lookup for RGB Video

The block corrects the tone of streaming RGB video one pixel at a time. Each colour channel has its own lookup table, and the incoming channel value is the read address. The word stored at that address becomes the corrected value. The output is registered and appears a fixed two clocks after the input. The horizontal sync, vertical sync and data-enable signals pass through the same two-stage delay, so they stay aligned with the corrected pixels.

Each table can hold two banks. The active bank serves the video. The host writes new curve values into the shadow bank through a small write port, while the active bank keeps serving the frame that is on screen. A swap request from the host is held until the next rising edge of vertical sync. At that point the two banks exchange roles, so no visible frame ever mixes an old curve with a new one. A small swap controller handles this with three states:
- `SW_IDLE`: no request is pending.
- `SW_ARMED`: a request is held and the controller waits for the vertical-sync rise.
- `SW_COMMIT`: a single cycle in which the bank pointer flips.

The transitions are:
- IDLE→ARMED on a request.
- ARMED→COMMIT on a vertical-sync rise.
- COMMIT→ARMED if a new request arrives in that cycle.
- COMMIT→IDLE otherwise.

When the `DOUBLE_BUF` parameter is 0, each table has only one bank. Host writes then change the table in use at once, and swap requests are ignored.

A bypass input sends the pixel around the tables with the same latency. When the `INTERP` parameter is 1, each table holds only a quarter of the entries. The upper pixel bits then pick two neighbouring entries, and the two low bits weight between them in quarter steps. Pixel width is set by `PIX_W`, which may be from 8 to 12.

Top module: `rgb_tone_remap`

## Requirements
- R1: While `rst_n` is low, all colour outputs and `out_hs`, `out_vs` and `out_de` are 0, whatever the inputs are.
- R2: With bypass off and `INTERP`=0, each of `out_r`, `out_g` and `out_b` equals the entry of its own channel's active table at the address given by that channel's input pixel. The output appears two clock edges after the input is sampled.
- R3: `out_hs`, `out_vs` and `out_de` equal `in_hs`, `in_vs` and `in_de` delayed by exactly two clock edges.
- R4: Host writes made while a table is active do not change the corrected output until a swap has completed.
- R5: A swap request (a one-cycle pulse on `cfg_swap`) is held. The active and shadow banks exchange only after the next rising edge of `in_vs`, however many cycles that takes. Pixels sampled after that rise use the new bank.
- R6: A request is used up by the swap it causes. A later rising edge of `in_vs` with no new request leaves the active bank unchanged.
- R7: With `cfg_bypass` high when a pixel is sampled, each output equals that pixel's input value, delayed by two clock edges.
- R8: `cfg_chan` selects which table a write goes to: 0 is red, 1 is green, 2 is blue. A write with code 3 changes no table.
- R9: A host write that lands in the cycle where the bank pointer flips (one clock after the edge that samples the `in_vs` rise) goes to the new shadow bank. It therefore becomes visible only after the following swap.
- R10: With `INTERP`=1, let k be `pix[PIX_W-1:2]` and f be `pix[1:0]`. The output is floor((e[k]·(4−f) + e[k+1]·f)/4), where e is the table. At the top index, e[k+1] is replaced by e[k].
- R11: With `DOUBLE_BUF`=0, a host write is visible in the next sampled pixel, and swap requests have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Host table write strobe |
| cfg_chan | input | 2 | Target table: 0 red, 1 green, 2 blue, 3 none |
| cfg_idx | input | INDEX_W | Table entry index (PIX_W, or PIX_W-2 when interpolating) |
| cfg_val | input | PIX_W | Value written to the entry |
| cfg_swap | input | 1 | One-cycle request to exchange the banks at the next frame gap |
| cfg_bypass | input | 1 | Pass pixels through uncorrected |
| in_r | input | PIX_W | Red input pixel |
| in_g | input | PIX_W | Green input pixel |
| in_b | input | PIX_W | Blue input pixel |
| in_hs | input | 1 | Horizontal sync in |
| in_vs | input | 1 | Vertical sync in, active high; a rise marks the frame gap |
| in_de | input | 1 | Data enable in |
| out_r | output | PIX_W | Corrected red |
| out_g | output | PIX_W | Corrected green |
| out_b | output | PIX_W | Corrected blue |
| out_hs | output | 1 | Horizontal sync, delayed two clocks |
| out_vs | output | 1 | Vertical sync, delayed two clocks |
| out_de | output | 1 | Data enable, delayed two clocks |

## Verification
The collision that matters is a host table write and the bank flip landing in the same clock. At that moment the write target moves from one bank to the other, and the written word could end up in the table that is about to be displayed. The bench first arms a swap. It then raises `in_vs`, and on the very next clock it writes a known value to one red entry. It judges the result by reading that pixel back through the video path twice. Right after the swap, the entry must still hold the old curve. After one more swap, the entry must hold the written value. In the same sequence, a write with channel code 3 is shown to leave all three tables untouched.

// File: rtl/tone_remap_pkg.sv
package tone_remap_pkg;

    localparam int NUM_CH = 3;

    typedef enum logic [1:0] {
        SW_IDLE   = 2'd0,
        SW_ARMED  = 2'd1,
        SW_COMMIT = 2'd2
    } swap_state_e;

endpackage

// File: rtl/tone_swap_ctrl.sv
module tone_swap_ctrl
    import tone_remap_pkg::*;
#(
    parameter int DOUBLE_BUF = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        swap_req,
    input  logic        vs_in,
    output logic        act_bank,
    output logic        wr_bank,
    output swap_state_e state_o
);

    swap_state_e state_q, state_d;
    logic        vs_q;
    logic        vs_rise;
    logic        req_ok;
    logic        bank_q;

    assign vs_rise = vs_in & ~vs_q;
    assign req_ok  = swap_req && (DOUBLE_BUF != 0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SW_IDLE;
            vs_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            vs_q    <= vs_in;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SW_IDLE:   if (req_ok)  state_d = SW_ARMED;
            SW_ARMED:  if (vs_rise) state_d = SW_COMMIT;
            SW_COMMIT: state_d = req_ok ? SW_ARMED : SW_IDLE;
            default:   state_d = SW_IDLE;
        endcase
    end

    // outputs: bank pointer flips while in COMMIT
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= 1'b0;
        end else if (state_q == SW_COMMIT) begin
            bank_q <= ~bank_q;
        end
    end

    assign act_bank = bank_q;
    // a write during COMMIT targets the bank that becomes shadow
    assign wr_bank  = ~(bank_q ^ (state_q == SW_COMMIT));
    assign state_o  = state_q;

endmodule

// File: rtl/tone_lut_ram.sv
module tone_lut_ram #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 9,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr0,
    input  logic [ADDR_W-1:0] raddr1,
    output logic [DATA_W-1:0] rdata0,
    output logic [DATA_W-1:0] rdata1
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata0 <= mem[raddr0];
        rdata1 <= mem[raddr1];
    end

endmodule

// File: rtl/tone_blend.sv
module tone_blend #(
    parameter int PIX_W = 8,
    localparam int SW   = PIX_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] lo,
    input  logic [PIX_W-1:0] hi,
    input  logic [1:0]       frac,
    input  logic [PIX_W-1:0] pix,
    input  logic             byp,
    output logic [PIX_W-1:0] res
);

    logic [SW-1:0] lo_x, hi_x, w_hi, w_lo, mix;

    always_comb begin
        lo_x = SW'(lo);
        hi_x = SW'(hi);
        w_hi = SW'(frac);
        w_lo = SW'(4) - w_hi;
        mix  = lo_x * w_lo + hi_x * w_hi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res <= '0;
        end else begin
            res <= byp ? pix : PIX_W'(mix >> 2);
        end
    end

endmodule

// File: rtl/rgb_tone_remap.sv
module rgb_tone_remap
    import tone_remap_pkg::*;
#(
    parameter int PIX_W      = 8,
    parameter int INTERP     = 0,
    parameter int DOUBLE_BUF = 1,
    localparam int INDEX_W   = (INTERP != 0) ? PIX_W - 2 : PIX_W,
    localparam int BANK_W    = (DOUBLE_BUF != 0) ? 1 : 0,
    localparam int AW        = INDEX_W + BANK_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_chan,
    input  logic [INDEX_W-1:0] cfg_idx,
    input  logic [PIX_W-1:0]   cfg_val,
    input  logic               cfg_swap,
    input  logic               cfg_bypass,
    input  logic [PIX_W-1:0]   in_r,
    input  logic [PIX_W-1:0]   in_g,
    input  logic [PIX_W-1:0]   in_b,
    input  logic               in_hs,
    input  logic               in_vs,
    input  logic               in_de,
    output logic [PIX_W-1:0]   out_r,
    output logic [PIX_W-1:0]   out_g,
    output logic [PIX_W-1:0]   out_b,
    output logic               out_hs,
    output logic               out_vs,
    output logic               out_de
);

    logic        act_bank;
    logic        wr_bank;
    swap_state_e swap_state;

    tone_swap_ctrl #(.DOUBLE_BUF(DOUBLE_BUF)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .swap_req (cfg_swap),
        .vs_in    (in_vs),
        .act_bank (act_bank),
        .wr_bank  (wr_bank),
        .state_o  (swap_state)
    );

    logic [PIX_W-1:0] pix_in [NUM_CH];
    logic [PIX_W-1:0] ch_res [NUM_CH];
    assign pix_in[0] = in_r;
    assign pix_in[1] = in_g;
    assign pix_in[2] = in_b;

    // sync / bypass pipeline (stage 1 and stage 2)
    logic [2:0] sync_s1, sync_s2;
    logic       byp_s1;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_s1 <= '0;
            sync_s2 <= '0;
            byp_s1  <= 1'b0;
        end else begin
            sync_s1 <= {in_hs, in_vs, in_de};
            sync_s2 <= sync_s1;
            byp_s1  <= cfg_bypass;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [INDEX_W-1:0] idx0, idx1;
        logic [1:0]         frac, frac_s1;
        logic [PIX_W-1:0]   pix_s1, lo_q, hi_q;
        logic [AW-1:0]      waddr, raddr0, raddr1;
        logic               we_c;

        assign we_c = cfg_we && (cfg_chan == 2'(c));

        if (INTERP != 0) begin : g_ip
            assign idx0 = pix_in[c][PIX_W-1:2];
            assign idx1 = (&idx0) ? idx0 : idx0 + INDEX_W'(1);
            assign frac = pix_in[c][1:0];
        end else begin : g_dir
            assign idx0 = pix_in[c];
            assign idx1 = idx0;
            assign frac = 2'b00;
        end

        if (DOUBLE_BUF != 0) begin : g_dbl
            assign waddr  = {wr_bank, cfg_idx};
            assign raddr0 = {act_bank, idx0};
            assign raddr1 = {act_bank, idx1};
        end else begin : g_sgl
            assign waddr  = cfg_idx;
            assign raddr0 = idx0;
            assign raddr1 = idx1;
        end

        tone_lut_ram #(.DATA_W(PIX_W), .ADDR_W(AW)) u_ram (
            .clk    (clk),
            .we     (we_c),
            .waddr  (waddr),
            .wdata  (cfg_val),
            .raddr0 (raddr0),
            .raddr1 (raddr1),
            .rdata0 (lo_q),
            .rdata1 (hi_q)
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pix_s1  <= '0;
                frac_s1 <= '0;
            end else begin
                pix_s1  <= pix_in[c];
                frac_s1 <= frac;
            end
        end

        tone_blend #(.PIX_W(PIX_W)) u_blend (
            .clk   (clk),
            .rst_n (rst_n),
            .lo    (lo_q),
            .hi    (hi_q),
            .frac  (frac_s1),
            .pix   (pix_s1),
            .byp   (byp_s1),
            .res   (ch_res[c])
        );
    end

    assign out_r  = ch_res[0];
    assign out_g  = ch_res[1];
    assign out_b  = ch_res[2];
    assign out_hs = sync_s2[2];
    assign out_vs = sync_s2[1];
    assign out_de = sync_s2[0];

endmodule

// File: rtl/rgb_tone_remap_chk.sv
module rgb_tone_remap_chk
    import tone_remap_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_bypass,
    input logic [PIX_W-1:0] in_r,
    input logic [PIX_W-1:0] in_g,
    input logic [PIX_W-1:0] in_b,
    input logic             in_hs,
    input logic             in_vs,
    input logic             in_de,
    input logic [PIX_W-1:0] out_r,
    input logic [PIX_W-1:0] out_g,
    input logic [PIX_W-1:0] out_b,
    input logic             out_hs,
    input logic             out_vs,
    input logic             out_de,
    input logic             act_bank,
    input swap_state_e      swap_state
);

    logic [1:0] cyc;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cyc <= '0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    a_r3_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd2) |-> (out_hs == $past(in_hs, 2) && out_vs == $past(in_vs, 2)
                           && out_de == $past(in_de, 2)));

    a_r7_bypass_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd2 && $past(cfg_bypass, 2)) |->
            (out_r == $past(in_r, 2) && out_g == $past(in_g, 2) && out_b == $past(in_b, 2)));

    a_r5_swap_in_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3 && act_bank != $past(act_bank)) |-> $past(in_vs, 2));

    a_r5_commit_from_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd1 && swap_state == SW_COMMIT) |-> ($past(swap_state) == SW_ARMED));

    a_r6_commit_once: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_state == SW_COMMIT) |=> (swap_state != SW_COMMIT));

endmodule

bind rgb_tone_remap rgb_tone_remap_chk #(.PIX_W(PIX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_bypass (cfg_bypass),
    .in_r       (in_r),
    .in_g       (in_g),
    .in_b       (in_b),
    .in_hs      (in_hs),
    .in_vs      (in_vs),
    .in_de      (in_de),
    .out_r      (out_r),
    .out_g      (out_g),
    .out_b      (out_b),
    .out_hs     (out_hs),
    .out_vs     (out_vs),
    .out_de     (out_de),
    .act_bank   (act_bank),
    .swap_state (swap_state)
);

// File: tb/rgb_tone_remap_tb.sv
module rgb_tone_remap_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       we_m = 0, we_s = 0, we_i = 0;
    logic [1:0] cchan = 0;
    logic [7:0] cidx = 0;
    logic [9:0] cval = 0;
    logic       cswap = 0, cbyp = 0;
    logic [9:0] px_r = 0, px_g = 0, px_b = 0;
    logic       hs = 0, vs = 0, de = 0;

    logic [7:0] m_r, m_g, m_b, s_r, s_g, s_b;
    logic [9:0] i_r, i_g, i_b;
    logic       m_hs, m_vs, m_de, s_hs, s_vs, s_de, i_hs, i_vs, i_de;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rgb_tone_remap #(.PIX_W(8), .INTERP(0), .DOUBLE_BUF(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(we_m), .cfg_chan(cchan), .cfg_idx(cidx),
        .cfg_val(cval[7:0]), .cfg_swap(cswap), .cfg_bypass(cbyp),
        .in_r(px_r[7:0]), .in_g(px_g[7:0]), .in_b(px_b[7:0]),
        .in_hs(hs), .in_vs(vs), .in_de(de),
        .out_r(m_r), .out_g(m_g), .out_b(m_b), .out_hs(m_hs), .out_vs(m_vs), .out_de(m_de));

    rgb_tone_remap #(.PIX_W(8), .INTERP(0), .DOUBLE_BUF(0)) u_dut_sb (
        .clk(clk), .rst_n(rst_n), .cfg_we(we_s), .cfg_chan(cchan), .cfg_idx(cidx),
        .cfg_val(cval[7:0]), .cfg_swap(cswap), .cfg_bypass(cbyp),
        .in_r(px_r[7:0]), .in_g(px_g[7:0]), .in_b(px_b[7:0]),
        .in_hs(hs), .in_vs(vs), .in_de(de),
        .out_r(s_r), .out_g(s_g), .out_b(s_b), .out_hs(s_hs), .out_vs(s_vs), .out_de(s_de));

    rgb_tone_remap #(.PIX_W(10), .INTERP(1), .DOUBLE_BUF(1)) u_dut_ip (
        .clk(clk), .rst_n(rst_n), .cfg_we(we_i), .cfg_chan(cchan), .cfg_idx(cidx),
        .cfg_val(cval), .cfg_swap(cswap), .cfg_bypass(cbyp),
        .in_r(px_r), .in_g(px_g), .in_b(px_b),
        .in_hs(hs), .in_vs(vs), .in_de(de),
        .out_r(i_r), .out_g(i_g), .out_b(i_b), .out_hs(i_hs), .out_vs(i_vs), .out_de(i_de));

    // ---------------- reference curves ----------------
    function automatic int tbl1(int ch, int i);
        case (ch)
            0: return (i * i) >> 8;
            1: return 255 - i;
            default: return (i * 3) & 255;
        endcase
    endfunction

    function automatic int tbl2(int ch, int i);
        case (ch)
            0: return i ^ 8'h5A;
            1: return (i + 37) & 255;
            default: return 255 - ((i * i) >> 8);
        endcase
    endfunction

    function automatic int ipt(int ch, int k);
        case (ch)
            0: return 4 * k;
            1: return 1023 - 4 * k;
            default: return (k * k) >> 6;
        endcase
    endfunction

    function automatic int exp_ip(int ch, int p);
        int k, f, kn;
        k  = p >> 2;
        f  = p & 3;
        kn = (k == 255) ? k : k + 1;
        return (ipt(ch, k) * (4 - f) + ipt(ch, kn) * f) >> 2;
    endfunction

    // ---------------- helpers ----------------
    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic host_wr(int which, int ch, int idx, int val);
        cchan = 2'(ch); cidx = 8'(idx); cval = 10'(val);
        we_m = (which == 0); we_s = (which == 1); we_i = (which == 2);
        @(negedge clk);
        we_m = 0; we_s = 0; we_i = 0;
    endtask

    task automatic swap_pulse();
        cswap = 1; @(negedge clk); cswap = 0; @(negedge clk);
    endtask

    task automatic vs_pulse();
        vs = 1; repeat (4) @(negedge clk);
        vs = 0; repeat (3) @(negedge clk);
    endtask

    task automatic px(int r, int g, int b);
        px_r = 10'(r); px_g = 10'(g); px_b = 10'(b);
        repeat (2) @(negedge clk);
    endtask

    task automatic check_main_tbl(string tag, int set, int r, int g, int b);
        px(r, g, b);
        check(tag, m_r, set == 1 ? tbl1(0, r) : tbl2(0, r));
        check(tag, m_g, set == 1 ? tbl1(1, g) : tbl2(1, g));
        check(tag, m_b, set == 1 ? tbl1(2, b) : tbl2(2, b));
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        px_r = 10'h3FF; px_g = 10'h3FF; px_b = 10'h3FF; hs = 1; de = 1; vs = 0;
        repeat (3) @(negedge clk);
        check("R1 out_r in reset", m_r, 0);
        check("R1 out_g in reset", m_g, 0);
        check("R1 out_b in reset", m_b, 0);
        check("R1 syncs in reset", {m_hs, m_vs, m_de}, 0);
        hs = 0; de = 0; px_r = 0; px_g = 0; px_b = 0;
        rst_n = 1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_load_first();
        for (int ch = 0; ch < 3; ch++)
            for (int i = 0; i < 256; i++) begin
                host_wr(0, ch, i, tbl1(ch, i));
                host_wr(2, ch, i, ipt(ch, i));
            end
        swap_pulse();
        vs_pulse();
    endtask

    task automatic t_lookup();
        check_main_tbl("R2 lookup a", 1, 0, 0, 0);
        check_main_tbl("R2 lookup b", 1, 255, 255, 255);
        check_main_tbl("R2 lookup c", 1, 17, 200, 93);
        check_main_tbl("R2 lookup d", 1, 128, 1, 254);
    endtask

    task automatic t_interp();
        int pl [6] = '{0, 1, 341, 1022, 1023, 679};
        foreach (pl[j]) begin
            px(pl[j], pl[j], pl[j]);
            check("R10 interp red", i_r, exp_ip(0, pl[j]));
            check("R10 interp green", i_g, exp_ip(1, pl[j]));
            check("R10 interp blue", i_b, exp_ip(2, pl[j]));
        end
        px(1023, 2, 515);
        check("R10 top clamp red", i_r, ipt(0, 255));
        check("R10 mix green", i_g, exp_ip(1, 2));
        check("R10 mix blue", i_b, exp_ip(2, 515));
    endtask

    task automatic t_sync();
        hs = 1; de = 0; vs = 0;
        @(negedge clk);
        check("R3 hs not yet", m_hs, 0);
        @(negedge clk);
        check("R3 hs after two", m_hs, 1);
        check("R3 de after two", m_de, 0);
        hs = 0; de = 1; vs = 1;
        repeat (2) @(negedge clk);
        check("R3 de after two", m_de, 1);
        check("R3 vs after two", m_vs, 1);
        check("R3 hs after two", m_hs, 0);
        vs = 0; de = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_shadow();
        for (int ch = 0; ch < 3; ch++)
            for (int i = 0; i < 256; i++) host_wr(0, ch, i, tbl2(ch, i));
        check_main_tbl("R4 shadow hidden", 1, 40, 90, 160);
        swap_pulse();
        repeat (20) @(negedge clk);
        check_main_tbl("R5 no swap before vs", 1, 40, 90, 160);
        vs_pulse();
        check_main_tbl("R5 swap after vs", 2, 40, 90, 160);
        vs_pulse();
        check_main_tbl("R6 no second swap", 2, 40, 90, 160);
    endtask

    task automatic t_bypass();
        cbyp = 1;
        px(10'h1A5, 10'h0F0, 10'h3C3);
        check("R7 bypass red", m_r, 8'hA5);
        check("R7 bypass green", m_g, 8'hF0);
        check("R7 bypass blue", m_b, 8'hC3);
        check("R7 bypass interp red", i_r, 10'h1A5);
        check("R7 bypass interp blue", i_b, 10'h3C3);
        cbyp = 0;
        check_main_tbl("R7 bypass off", 2, 33, 33, 33);
    endtask

    task automatic t_commit_write();
        // active = curve 2, shadow = curve 1
        host_wr(0, 3, 10, 8'h99);
        swap_pulse();
        vs = 1;
        @(negedge clk);
        cchan = 0; cidx = 20; cval = 10'h077; we_m = 1;
        @(negedge clk);
        we_m = 0;
        repeat (3) @(negedge clk);
        vs = 0;
        repeat (3) @(negedge clk);
        check_main_tbl("R8 code 3 no write", 1, 10, 10, 10);
        px(20, 0, 0);
        check("R9 commit-cycle write hidden", m_r, tbl1(0, 20));
        swap_pulse();
        vs_pulse();
        px(20, 0, 0);
        check("R9 commit-cycle write in new shadow", m_r, 8'h77);
        check_main_tbl("R8 code 3 no write", 2, 10, 10, 10);
    endtask

    task automatic t_single();
        host_wr(1, 1, 5, 8'h33);
        px(0, 5, 0);
        check("R11 direct write", s_g, 8'h33);
        swap_pulse();
        vs_pulse();
        px(0, 5, 0);
        check("R11 swap ignored", s_g, 8'h33);
        host_wr(1, 1, 5, 8'h44);
        px(0, 5, 0);
        check("R11 rewrite direct", s_g, 8'h44);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_load_first();
        t_lookup();
        t_interp();
        t_sync();
        t_shadow();
        t_bypass();
        t_commit_write();
        t_single();
        done = 1;
        summary();
        $finish;
    end

endmodule